// File: doc/BRIEF.md
# Edge-Triggered Tri-State Phase-Frequency Detector

This block compares a reference signal against the divided-down feedback from a PLL oscillator and produces a three-level pump command for a loop filter. A fast system clock samples both single-bit inputs. Each input passes through a synchronizer. A rising edge is recorded when one synchronized sample is 0 and the next is 1. Only rising edges matter, so the duty cycle of either input does not affect the result.

The pump command is encoded with an enable bit and a level bit. With the enable clear the output is released, which is the high-impedance idle state. With the enable set and the level high the output pumps up. With the enable set and the level low it pumps down. A separate phase-pulse output is high whenever the pump is released, so the surrounding logic can use it as a lock indication.

A reference edge that arrives first starts pump-up, which lasts until a feedback edge arrives. A feedback edge that arrives first starts pump-down, which lasts until a reference edge arrives. A stray reference edge therefore keeps the pump driving up until the next feedback edge, however long that takes.

Top module: `pfd_tristate`

## Requirements
- R1: A synchronous active-high reset puts the block in the released state: drive_en=0, drive_hi=0, phase_ok=1.
- R2: Only 0-to-1 transitions of the synchronized inputs change the state. Falling edges, and an input held high or low, leave the outputs unchanged.
- R3: From the released state, a reference rising edge with no feedback rising edge in the same cycle gives pump-up (drive_en=1, drive_hi=1). Pump-up ends in the released state on the next feedback rising edge.
- R4: From the released state, a feedback rising edge with no reference rising edge in the same cycle gives pump-down (drive_en=1, drive_hi=0). Pump-down ends in the released state on the next reference rising edge.
- R5: phase_ok is 1 exactly when drive_en is 0. drive_hi is 0 whenever drive_en is 0.
- R6: Rising edges on both inputs in the same sampled cycle put the block in the released state, whatever the previous state was.
- R7: Further reference rising edges during pump-up, with no feedback edge, keep pump-up active.
- R8: Further feedback rising edges during pump-down keep pump-down active. With no reference edges at all, the output settles in pump-down and stays there.
- R9: An input rising edge set up before a clock edge changes the outputs right after the third rising clock edge, which is two synchronizer stages plus one state register.
- R10: When the feedback runs slower than the reference, pump-up is active for more than half the cycles. When it runs faster, pump-down is active for more than half the cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator divider, asynchronous |
| drive_en | output | 1 | Pump drive enable; 0 means released (high impedance) |
| drive_hi | output | 1 | Pump direction when enabled: 1 up, 0 down |
| phase_ok | output | 1 | High while the pump is released |

## Verification
The bench aims at edges that land in the same sampled cycle, which must release the pump. A design that favoured one input there would leave the pump driving. It also sends repeated edges on the same input: a stray reference edge must hold pump-up, and a design that toggled on every edge would release the pump early. Long high levels and falling edges check that the detector keys on edges rather than levels, since a level detector would drive for the whole duty cycle. The edge-to-output delay is checked cycle by cycle, which exposes a missing or extra synchronizer stage. Runs at mismatched frequencies check that the dominant direction follows whichever input is faster.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PUMP_OFF  = 2'd0,
    PUMP_UP   = 2'd1,
    PUMP_DOWN = 2'd2
  } pump_e;
endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain;
  logic         prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[MSB-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[MSB];
  end

  assign rise = chain[MSB] & ~prev;

  // R2: a detected edge needs a 0 before it, so two edges can never be adjacent
  p_rise_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic drive_en,
  output logic drive_hi,
  output logic phase_ok
);
  pump_e st, nxt;

  always_comb begin
    nxt = st;
    if (ref_rise && fb_rise)  nxt = PUMP_OFF;
    else if (ref_rise)        nxt = (st == PUMP_DOWN) ? PUMP_OFF : PUMP_UP;
    else if (fb_rise)         nxt = (st == PUMP_UP)   ? PUMP_OFF : PUMP_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PUMP_OFF;
      drive_en <= 1'b0;
      drive_hi <= 1'b0;
      phase_ok <= 1'b1;
    end else begin
      st       <= nxt;
      drive_en <= (nxt != PUMP_OFF);
      drive_hi <= (nxt == PUMP_UP);
      phase_ok <= (nxt == PUMP_OFF);
    end
  end

  // R5: lock pulse and drive enable are complementary
  p_lock_vs_drive_r5: assert property (@(posedge clk) disable iff (rst)
    phase_ok == !drive_en);
  // R5: level bit is quiet while released
  p_hi_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> !drive_hi);
  // R3: feedback edge releases pump-up
  p_up_release_r3: assert property (@(posedge clk) disable iff (rst)
    (st == PUMP_UP && fb_rise) |=> !drive_en);
  // R4: reference edge releases pump-down
  p_dn_release_r4: assert property (@(posedge clk) disable iff (rst)
    (st == PUMP_DOWN && ref_rise) |=> !drive_en);
  // R6: coincident edges release
  p_coincident_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise) |=> phase_ok);
  // R7: pump-up persists without a feedback edge
  p_up_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (st == PUMP_UP && !fb_rise) |=> (drive_en && drive_hi));
  // R8: pump-down persists without a reference edge
  p_dn_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st == PUMP_DOWN && !ref_rise) |=> (drive_en && !drive_hi));
  // R2: with no edges at all, the outputs do not move
  p_no_edge_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!ref_rise && !fb_rise && $past(!rst)) |=> ($stable(drive_en) && $stable(drive_hi)));
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic drive_en,
  output logic drive_hi,
  output logic phase_ok
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] din;
  logic [NUM_CH-1:0] rise;

  assign din = {fb_in, ref_in};

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pfd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (din[ch]),
        .rise (rise[ch])
      );
    end
  endgenerate

  pfd_core u_core (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .fb_rise  (rise[1]),
    .drive_en (drive_en),
    .drive_hi (drive_hi),
    .phase_ok (phase_ok)
  );
endmodule

// File: tb/pfd_tristate_bench.sv
module pfd_tristate_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_d = 1'b0;
  logic fb_d = 1'b0;
  logic drive_en, drive_hi, phase_ok;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  pfd_tristate u_pfd_tristate (
    .clk(clk), .rst(rst), .ref_in(ref_d), .fb_in(fb_d),
    .drive_en(drive_en), .drive_hi(drive_hi), .phase_ok(phase_ok)
  );

  // behavioural model: 0 released, 1 up, -1 down
  bit rq[$];
  bit fq[$];
  int mst = 0;

  always @(posedge clk) begin
    if (rst) begin
      rq = '{0, 0, 0, 0};
      fq = '{0, 0, 0, 0};
      mst = 0;
    end else begin
      bit r, f;
      rq.push_front(ref_d); void'(rq.pop_back());
      fq.push_front(fb_d);  void'(fq.pop_back());
      r = rq[2] && !rq[3];
      f = fq[2] && !fq[3];
      if (r && f)  mst = 0;
      else if (r)  mst = (mst == -1) ? 0 : 1;
      else if (f)  mst = (mst == 1) ? 0 : -1;
    end
  end

  task automatic check(string req, bit en, bit hi, bit ok);
    checks++;
    if ({drive_en, drive_hi, phase_ok} !== {en, hi, ok}) begin
      fails++;
      $display("FAIL %s en/hi/ok got %b%b%b expected %b%b%b at %0t",
               req, drive_en, drive_hi, phase_ok, en, hi, ok, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(tag, mst != 0, mst == 1, mst == 0);
      checks++;
      if (phase_ok !== !drive_en) begin
        fails++;
        $display("FAIL R5 phase_ok got %b expected %b", phase_ok, !drive_en);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit r, bit f);
    @(negedge clk);
    ref_d = r;
    fb_d = f;
  endtask

  int up_cnt, dn_cnt;

  task automatic periodic(bit use_ref, int pr, int pf, int off, int n);
    up_cnt = 0; dn_cnt = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (drive_en && drive_hi) up_cnt++;
      if (drive_en && !drive_hi) dn_cnt++;
      ref_d = use_ref ? ((c % pr) < pr / 2) : 1'b0;
      fb_d  = ((c + off) % pf) < pf / 2;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b1);
    cmp_on = 1'b1;

    // R9: exact latency from a reference edge
    tag = "R9";
    idle(5);
    @(negedge clk); ref_d = 1'b1;
    @(negedge clk); check("R9", 1'b0, 1'b0, 1'b1);
    @(negedge clk); check("R9", 1'b0, 1'b0, 1'b1);
    @(negedge clk); check("R9", 1'b1, 1'b1, 1'b0);

    // R3: feedback edge releases pump-up
    tag = "R3";
    idle(6); drive(1'b0, 1'b1); idle(3); drive(1'b0, 1'b0); idle(2);
    check("R3", 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0); idle(8); drive(1'b0, 1'b0); idle(4); drive(1'b0, 1'b1); idle(6);

    // R4: feedback first, then reference
    tag = "R4";
    drive(1'b0, 1'b0); drive(1'b0, 1'b1); idle(5);
    check("R4", 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1); idle(6);
    check("R4", 1'b0, 1'b0, 1'b1);

    // R6: coincident edges from idle and from pump-up
    tag = "R6";
    drive(1'b0, 1'b0); idle(3); drive(1'b1, 1'b1); idle(6);
    check("R6", 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b0, 1'b0); idle(4);
    drive(1'b1, 1'b1); idle(6);
    check("R6", 1'b0, 1'b0, 1'b1);

    // R2: long high level and falling edges do nothing further
    tag = "R2";
    drive(1'b0, 1'b0); idle(3); drive(1'b1, 1'b0); idle(40);
    check("R2", 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0); idle(10);
    check("R2", 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1); idle(30); drive(1'b0, 1'b0); idle(10);
    check("R2", 1'b0, 1'b0, 1'b1);

    // R7: stray reference edges hold pump-up
    tag = "R7";
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); idle(3);
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); idle(3);
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); idle(60);
    check("R7", 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); idle(5);

    // R8: feedback only, no reference edges
    tag = "R8";
    periodic(1'b0, 1, 24, 0, 300);
    idle(4);
    check("R8", 1'b1, 1'b0, 1'b0);

    // R10: feedback slower, then faster
    tag = "R10";
    drive(1'b1, 1'b1); drive(1'b0, 1'b0); idle(6);
    periodic(1'b1, 40, 52, 7, 2000);
    checks++;
    if (up_cnt * 2 <= 2000) begin
      fails++; $display("FAIL R10 up cycles got %0d expected >1000", up_cnt);
    end
    periodic(1'b1, 40, 30, 3, 2000);
    checks++;
    if (dn_cnt * 2 <= 2000) begin
      fails++; $display("FAIL R10 down cycles got %0d expected >1000", dn_cnt);
    end
    idle(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule